// File: doc/BRIEF.md
# Piecewise-Linear Chroma Gain Interpolator

This block turns the present white-balance red factor into four chrominance gains and applies them to a pair of signed colour-difference samples. The four gain channels are R-Y negative, R-Y positive, B-Y negative and B-Y positive. Each channel has its own curve. The curve is set by three shared breakpoints on the factor axis and by per-channel anchor gains and signed slopes.

Every cycle the factor is placed in one of five regions: below the first breakpoint, the first ramp, exactly on the middle breakpoint, the second ramp, or above. Every channel's gain is then taken from its anchor or interpolated along its slope. In the same cycle the R-Y sample and the B-Y sample each pick the gain that matches their sign. The product is rounded and saturated, and it appears on the outputs one clock later, together with the four gains.

Top module: `chroma_gain_interp`

## Requirements
- R1: While `rst` is high at a rising edge, every gain output and both sample outputs read zero after that edge.
- R2: When the factor is less than or equal to breakpoint 1 (`bp_i[0]`), each channel's gain is its anchor 1 (`anch_i[k][0]`). Channel index k is 0 = R-Y negative, 1 = R-Y positive, 2 = B-Y negative, 3 = B-Y positive.
- R3: When the factor is above breakpoint 1 and below breakpoint 2 (`bp_i[1]`), the gain is anchor 1 plus floor(slope_a × (factor − bp1) / 2^SHIFT), clamped to 0..2^GW−1. Here slope_a (`slope_i[k][0]`) is a two's-complement SW-bit value and SHIFT defaults to 4.
- R4: When the factor is above breakpoint 1 and equal to breakpoint 2, the gain is anchor 2 (`anch_i[k][1]`).
- R5: When the factor is above breakpoint 2 and below breakpoint 3 (`bp_i[2]`), the gain is anchor 2 plus floor(slope_b × (factor − bp2) / 2^SHIFT), clamped as in R3. Here slope_b is `slope_i[k][1]`.
- R6: When the factor is above breakpoints 1 and 2 and at or above breakpoint 3, the gain is anchor 3 (`anch_i[k][2]`).
- R7: The regions are tested in a fixed order: ≤bp1, <bp2, =bp2, <bp3, otherwise above. With breakpoints out of order, the first test that matches decides.
- R8: The four channels are independent: each channel's gain depends only on its own anchors and slopes.
- R9: A sample that is zero or positive uses the positive-direction gain of its axis, and a negative sample uses the negative-direction gain. R-Y uses channels 0/1 and B-Y uses channels 2/3.
- R10: The scaled sample is floor((sample × gain + 2^(GFRAC−1)) / 2^GFRAC), saturated to the signed DW-bit range. GFRAC defaults to 6, so a gain of 64 is unity.
- R11: The gains and both scaled samples are registered. Outputs after edge n reflect the inputs present at edge n, and no input reaches an output without passing through a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| factor_i | input | FW | Present white-balance red factor |
| bp_i | input | 3×FW | Breakpoints 1..3 at indices 0..2 |
| anch_i | input | 4×3×GW | Anchor gain per channel and breakpoint |
| slope_i | input | 4×2×SW | Signed slope per channel for ramp 1 and ramp 2 |
| ry_i | input | DW | Signed R-Y sample |
| by_i | input | DW | Signed B-Y sample |
| gain_o | output | 4×GW | Registered gain per channel |
| ry_o | output | DW | Registered scaled R-Y sample |
| by_o | output | DW | Registered scaled B-Y sample |

## Verification
The factor is swept through each region. This includes the values exactly on, one below and one above every breakpoint, which separates inclusive comparisons from exclusive ones. The channels are programmed with a positive slope, a steep slope that clips at the top, a steep negative slope that clips at zero, and a small negative slope whose floor differs from truncation. Samples take both signs, zero, full scale and values of ±1, so that the choice of gain by sign, round-half-up and saturation are each seen on their own. Out-of-order breakpoints show the priority of the tests, and a check before the clock edge shows that the outputs are registered.

// File: rtl/cgi_pkg.sv
package cgi_pkg;

    localparam int NUM_CH    = 4;
    localparam int NUM_BP    = 3;
    localparam int NUM_SLOPE = NUM_BP - 1;

    // Region of the factor axis; the order of tests is fixed (see selector).
    typedef enum logic [2:0] {
        SEG_BELOW = 3'd0,
        SEG_RAMP1 = 3'd1,
        SEG_KNEE  = 3'd2,
        SEG_RAMP2 = 3'd3,
        SEG_ABOVE = 3'd4
    } seg_e;

    // Gain channel index; bit 1 = axis (B-Y), bit 0 = positive direction.
    typedef enum logic [1:0] {
        CH_RY_NEG = 2'd0,
        CH_RY_POS = 2'd1,
        CH_BY_NEG = 2'd2,
        CH_BY_POS = 2'd3
    } chan_e;

    function automatic logic [1:0] chan_of(input logic is_by, input logic is_neg);
        return {is_by, ~is_neg};
    endfunction

endpackage

// File: rtl/cgi_segment_sel.sv
module cgi_segment_sel
    import cgi_pkg::*;
#(
    parameter int FW = 9
) (
    input  logic [FW-1:0]             factor_i,
    input  logic [NUM_BP-1:0][FW-1:0] bp_i,
    output seg_e                      seg_o,
    output logic [FW-1:0]             delta_o
);

    // Priority chain: the first test that matches picks the region.
    always_comb begin
        seg_o   = SEG_BELOW;
        delta_o = '0;
        if (factor_i <= bp_i[0]) begin
            seg_o = SEG_BELOW;
        end else if (factor_i < bp_i[1]) begin
            seg_o   = SEG_RAMP1;
            delta_o = factor_i - bp_i[0];
        end else if (factor_i == bp_i[1]) begin
            seg_o = SEG_KNEE;
        end else if (factor_i < bp_i[2]) begin
            seg_o   = SEG_RAMP2;
            delta_o = factor_i - bp_i[1];
        end else begin
            seg_o = SEG_ABOVE;
        end
    end

endmodule

// File: rtl/cgi_gain_curve.sv
module cgi_gain_curve
    import cgi_pkg::*;
#(
    parameter int FW    = 9,
    parameter int GW    = 8,
    parameter int SW    = 7,
    parameter int SHIFT = 4
) (
    input  seg_e                         seg_i,
    input  logic [FW-1:0]                delta_i,
    input  logic [NUM_BP-1:0][GW-1:0]    anch_i,
    input  logic [NUM_SLOPE-1:0][SW-1:0] slope_i,
    output logic [GW-1:0]                gain_o
);

    localparam int PW = SW + FW + 2;
    localparam logic signed [PW-1:0] GMAX = PW'((1 << GW) - 1);

    logic [GW-1:0]          base;
    logic signed [SW-1:0]   slope_sel;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   step;
    logic signed [PW-1:0]   sum;

    always_comb begin
        base      = anch_i[0];
        slope_sel = '0;
        unique case (seg_i)
            SEG_BELOW: base = anch_i[0];
            SEG_RAMP1: begin
                base      = anch_i[0];
                slope_sel = $signed(slope_i[0]);
            end
            SEG_KNEE:  base = anch_i[1];
            SEG_RAMP2: begin
                base      = anch_i[1];
                slope_sel = $signed(slope_i[1]);
            end
            SEG_ABOVE: base = anch_i[2];
            default:   base = anch_i[0];
        endcase
    end

    always_comb begin
        prod = PW'(slope_sel) * $signed({{(PW-FW){1'b0}}, delta_i});
        step = prod >>> SHIFT;
        sum  = $signed({{(PW-GW){1'b0}}, base}) + step;
        if (sum < 0)
            gain_o = '0;
        else if (sum > GMAX)
            gain_o = '1;
        else
            gain_o = sum[GW-1:0];
    end

endmodule

// File: rtl/cgi_scaler.sv
module cgi_scaler #(
    parameter int DW    = 10,
    parameter int GW    = 8,
    parameter int GFRAC = 6
) (
    input  logic signed [DW-1:0] samp_i,
    input  logic [GW-1:0]        gain_i,
    output logic signed [DW-1:0] samp_o
);

    localparam int MW = DW + GW + 2;
    localparam logic signed [MW-1:0] HALF = MW'(1) << (GFRAC - 1);
    localparam logic signed [MW-1:0] YMAX = MW'((1 << (DW - 1)) - 1);
    localparam logic signed [MW-1:0] YMIN = ~YMAX;

    logic signed [MW-1:0] prod;
    logic signed [MW-1:0] rnd;

    always_comb begin
        prod = MW'(samp_i) * $signed({{(MW-GW){1'b0}}, gain_i});
        rnd  = (prod + HALF) >>> GFRAC;
        if (rnd > YMAX)
            samp_o = YMAX[DW-1:0];
        else if (rnd < YMIN)
            samp_o = YMIN[DW-1:0];
        else
            samp_o = rnd[DW-1:0];
    end

endmodule

// File: rtl/chroma_gain_interp.sv
module chroma_gain_interp
    import cgi_pkg::*;
#(
    parameter int FW    = 9,
    parameter int GW    = 8,
    parameter int SW    = 7,
    parameter int DW    = 10,
    parameter int SHIFT = 4,
    parameter int GFRAC = 6
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [FW-1:0]                             factor_i,
    input  logic [NUM_BP-1:0][FW-1:0]                 bp_i,
    input  logic [NUM_CH-1:0][NUM_BP-1:0][GW-1:0]     anch_i,
    input  logic [NUM_CH-1:0][NUM_SLOPE-1:0][SW-1:0]  slope_i,
    input  logic signed [DW-1:0]                      ry_i,
    input  logic signed [DW-1:0]                      by_i,
    output logic [NUM_CH-1:0][GW-1:0]                 gain_o,
    output logic signed [DW-1:0]                      ry_o,
    output logic signed [DW-1:0]                      by_o
);

    localparam int NUM_AX = 2;

    seg_e                        seg;
    logic [FW-1:0]               delta;
    logic [NUM_CH-1:0][GW-1:0]   gain_c;
    logic signed [DW-1:0]        samp_in  [NUM_AX];
    logic signed [DW-1:0]        samp_scl [NUM_AX];
    logic [GW-1:0]               gain_sel [NUM_AX];
    logic signed [DW-1:0]        samp_q   [NUM_AX];

    cgi_segment_sel #(.FW(FW)) u_sel (
        .factor_i (factor_i),
        .bp_i     (bp_i),
        .seg_o    (seg),
        .delta_o  (delta)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_curve
        cgi_gain_curve #(
            .FW(FW), .GW(GW), .SW(SW), .SHIFT(SHIFT)
        ) u_curve (
            .seg_i   (seg),
            .delta_i (delta),
            .anch_i  (anch_i[k]),
            .slope_i (slope_i[k]),
            .gain_o  (gain_c[k])
        );
    end

    assign samp_in[0] = ry_i;
    assign samp_in[1] = by_i;

    for (genvar a = 0; a < NUM_AX; a++) begin : g_axis
        assign gain_sel[a] = gain_c[chan_of(1'(a), samp_in[a][DW-1])];

        cgi_scaler #(.DW(DW), .GW(GW), .GFRAC(GFRAC)) u_scale (
            .samp_i (samp_in[a]),
            .gain_i (gain_sel[a]),
            .samp_o (samp_scl[a])
        );

        always_ff @(posedge clk) begin
            if (rst)
                samp_q[a] <= '0;
            else
                samp_q[a] <= samp_scl[a];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            gain_o <= '0;
        else
            gain_o <= gain_c;
    end

    assign ry_o = samp_q[0];
    assign by_o = samp_q[1];

endmodule

// File: rtl/chroma_gain_interp_chk.sv
module chroma_gain_interp_chk
    import cgi_pkg::*;
#(
    parameter int FW    = 9,
    parameter int GW    = 8,
    parameter int SW    = 7,
    parameter int DW    = 10,
    parameter int SHIFT = 4,
    parameter int GFRAC = 6
) (
    input logic                                      clk,
    input logic                                      rst,
    input logic [FW-1:0]                             factor_i,
    input logic [NUM_BP-1:0][FW-1:0]                 bp_i,
    input logic [NUM_CH-1:0][NUM_BP-1:0][GW-1:0]     anch_i,
    input logic [NUM_CH-1:0][NUM_SLOPE-1:0][SW-1:0]  slope_i,
    input logic signed [DW-1:0]                      ry_i,
    input logic signed [DW-1:0]                      by_i,
    input logic [NUM_CH-1:0][GW-1:0]                 gain_o,
    input logic signed [DW-1:0]                      ry_o,
    input logic signed [DW-1:0]                      by_o
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (gain_o == '0 && ry_o == '0 && by_o == '0));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        a_r2_below_anchor: assert property (@(posedge clk) disable iff (rst)
            (factor_i <= bp_i[0]) |=> gain_o[k] == $past(anch_i[k][0]));

        a_r3_ramp1_direction: assert property (@(posedge clk) disable iff (rst)
            (factor_i > bp_i[0] && factor_i < bp_i[1] && !slope_i[k][0][SW-1])
            |=> gain_o[k] >= $past(anch_i[k][0]));

        a_r4_knee_anchor: assert property (@(posedge clk) disable iff (rst)
            (factor_i > bp_i[0] && factor_i == bp_i[1])
            |=> gain_o[k] == $past(anch_i[k][1]));

        a_r5_ramp2_direction: assert property (@(posedge clk) disable iff (rst)
            (factor_i > bp_i[0] && factor_i > bp_i[1] && factor_i < bp_i[2]
             && slope_i[k][1][SW-1])
            |=> gain_o[k] <= $past(anch_i[k][1]));

        a_r6_above_anchor: assert property (@(posedge clk) disable iff (rst)
            (factor_i > bp_i[0] && factor_i > bp_i[1] && factor_i >= bp_i[2])
            |=> gain_o[k] == $past(anch_i[k][2]));
    end

    a_r9_sign_kept_ry: assert property (@(posedge clk) disable iff (rst)
        (ry_i > 0) |=> (ry_o >= 0));

    a_r9_sign_kept_by: assert property (@(posedge clk) disable iff (rst)
        (by_i < 0) |=> (by_o <= 0));

    a_r10_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
        (ry_i == '0 && by_i == '0) |=> (ry_o == '0 && by_o == '0));

endmodule

bind chroma_gain_interp chroma_gain_interp_chk #(
    .FW(FW), .GW(GW), .SW(SW), .DW(DW), .SHIFT(SHIFT), .GFRAC(GFRAC)
) u_chk (.*);

// File: tb/chroma_gain_interp_tb.sv
module chroma_gain_interp_tb;
    import cgi_pkg::*;

    localparam int FW = 9, GW = 8, SW = 7, DW = 10, SHIFT = 4, GFRAC = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                                      rst;
    logic [FW-1:0]                             factor_i;
    logic [NUM_BP-1:0][FW-1:0]                 bp_i;
    logic [NUM_CH-1:0][NUM_BP-1:0][GW-1:0]     anch_i;
    logic [NUM_CH-1:0][NUM_SLOPE-1:0][SW-1:0]  slope_i;
    logic signed [DW-1:0]                      ry_i, by_i;
    logic [NUM_CH-1:0][GW-1:0]                 gain_o;
    logic signed [DW-1:0]                      ry_o, by_o;

    chroma_gain_interp #(
        .FW(FW), .GW(GW), .SW(SW), .DW(DW), .SHIFT(SHIFT), .GFRAC(GFRAC)
    ) u_dut (
        .clk(clk), .rst(rst), .factor_i(factor_i), .bp_i(bp_i),
        .anch_i(anch_i), .slope_i(slope_i), .ry_i(ry_i), .by_i(by_i),
        .gain_o(gain_o), .ry_o(ry_o), .by_o(by_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    int bp [NUM_BP];
    int an [NUM_CH][NUM_BP];
    int sl [NUM_CH][NUM_SLOPE];

    // factor, R-Y sample, B-Y sample
    localparam int NV = 12;
    localparam int VEC [NV][3] = '{
        '{  0,  100, -100}, '{100,  511, -512}, '{101,   -1,    1},
        '{150,  300, -300}, '{199,  200,  200}, '{200, -200,   -7},
        '{201,    0,    0}, '{250,   33,  -33}, '{299,  511, -512},
        '{300,    1,   -1}, '{511, -512,  511}, '{350,   64,  -64}
    };

    function automatic int model_gain(int k, int f);
        int v;
        if (f <= bp[0]) return an[k][0];
        if (f < bp[1]) v = an[k][0] + ((sl[k][0] * (f - bp[0])) >>> SHIFT);
        else if (f == bp[1]) return an[k][1];
        else if (f < bp[2]) v = an[k][1] + ((sl[k][1] * (f - bp[1])) >>> SHIFT);
        else return an[k][2];
        if (v < 0) v = 0;
        if (v > (1 << GW) - 1) v = (1 << GW) - 1;
        return v;
    endfunction

    function automatic int model_scale(int s, int g);
        int q;
        q = (s * g + (1 << (GFRAC - 1))) >>> GFRAC;
        if (q > (1 << (DW - 1)) - 1) q = (1 << (DW - 1)) - 1;
        if (q < -(1 << (DW - 1))) q = -(1 << (DW - 1));
        return q;
    endfunction

    function automatic string region_tag(int f);
        if (f <= bp[0]) return "R2";
        if (f < bp[1]) return "R3";
        if (f == bp[1]) return "R4";
        if (f < bp[2]) return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_cfg();
        for (int j = 0; j < NUM_BP; j++) bp_i[j] = FW'(bp[j]);
        for (int k = 0; k < NUM_CH; k++) begin
            for (int j = 0; j < NUM_BP; j++) anch_i[k][j] = GW'(an[k][j]);
            for (int j = 0; j < NUM_SLOPE; j++) slope_i[k][j] = SW'(sl[k][j]);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (one rising edge between).
    task automatic apply(int f, int ry, int by, string tag);
        factor_i = FW'(f);
        ry_i     = DW'(ry);
        by_i     = DW'(by);
        @(negedge clk);
        for (int k = 0; k < NUM_CH; k++)
            chk(tag, $sformatf("gain ch%0d f=%0d", k, f), int'(gain_o[k]), model_gain(k, f));
        chk("R9 R10", $sformatf("ry s=%0d f=%0d", ry, f), int'(ry_o),
            model_scale(ry, model_gain(ry < 0 ? 0 : 1, f)));
        chk("R9 R10", $sformatf("by s=%0d f=%0d", by, f), int'(by_o),
            model_scale(by, model_gain(by < 0 ? 2 : 3, f)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bp = '{100, 200, 300};
        an = '{'{64, 96, 128}, '{40, 200, 250}, '{200, 100, 10}, '{64, 64, 64}};
        sl = '{'{8, 8}, '{63, 63}, '{-64, -30}, '{-3, 5}};
        rst = 1'b1;
        push_cfg();
        factor_i = 9'd150;
        ry_i = 10'sd100;
        by_i = -10'sd100;

        // R1: reset state with non-zero inputs
        repeat (3) @(negedge clk);
        for (int k = 0; k < NUM_CH; k++) chk("R1", "reset gain", int'(gain_o[k]), 0);
        chk("R1", "reset ry", int'(ry_o), 0);
        chk("R1", "reset by", int'(by_o), 0);
        rst = 1'b0;

        // Table walk: regions, breakpoint edges, clipping, both signs (R2..R6, R8..R10)
        for (int v = 0; v < NV; v++)
            apply(VEC[v][0], VEC[v][1], VEC[v][2], region_tag(VEC[v][0]));

        // R11: outputs do not move before the rising edge
        factor_i = 9'd0;
        ry_i = 10'sd7;
        by_i = 10'sd7;
        #1;
        chk("R11", "gain ch0 before edge", int'(gain_o[0]), model_gain(0, 350));
        chk("R11", "ry before edge", int'(ry_o), model_scale(64, model_gain(1, 350)));
        apply(0, 7, 7, "R11");

        // R7: out-of-order breakpoints, first matching test decides
        bp = '{300, 200, 100};
        push_cfg();
        apply(250, 10, -10, "R7");
        apply(350, 10, -10, "R7");
        bp = '{50, 200, 150};
        push_cfg();
        apply(175, 20, -20, "R7");
        apply(200, 20, -20, "R7");
        apply(300, 20, -20, "R7");

        // R10: round-half-up and R9: zero takes the positive gain
        bp = '{100, 200, 300};
        an = '{'{32, 32, 32}, '{32, 32, 32}, '{64, 64, 64}, '{32, 32, 32}};
        push_cfg();
        apply(0, -1, 1, "R10");
        apply(0, 1, -1, "R10");
        apply(0, 3, 0, "R10");

        // R8: change one channel only, the others hold
        an[2][0] = 250;
        push_cfg();
        apply(0, -100, -100, "R8");

        // R1: reset in mid-run
        factor_i = 9'd150;
        ry_i = 10'sd200;
        by_i = 10'sd200;
        rst = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NUM_CH; k++) chk("R1", "mid reset gain", int'(gain_o[k]), 0);
        chk("R1", "mid reset ry", int'(ry_o), 0);
        chk("R1", "mid reset by", int'(by_o), 0);
        rst = 1'b0;
        apply(150, 200, 200, "R3");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule